// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Unit

This block sits on the memory side and owns a small local RAM that is 64 bits wide and read synchronously. It carries out one indivisible compare-and-swap per request. A requester offers a byte address, an operand size, compare data, swap data, two ordering flags and a write-permission flag, using a valid/ready handshake. The unit reads the addressed location and compares it bit for bit against the compare data. It stores the swap data only when the two are identical. It then answers with the value it read, a success flag, a fault code and the effective ordering flags.

A word uses one 32-bit lane of a RAM row. A doubleword fills one whole row. A quadword spans two consecutive rows, so it needs two read beats and, on success, two write beats. While those beats run, a lock output tells any other memory port to stay off the RAM. The test for a quadword is one all-or-nothing equality over all 128 bits. A failed compare writes nothing back. A faulting request never reaches the RAM.

Top module: `cas_unit`

## Requirements
- R1: Size code 0 is a 32-bit word. It needs a 4-byte aligned address and uses the row at address bits [AW-1:3], with lane bits [31:0] when address bit 2 is 0 and bits [63:32] when it is 1. Size code 1 is a 64-bit doubleword that occupies one full row. Size code 2 is a 128-bit quadword: its low half is in the even row at the base address and its high half is in the next row.
- R2: The swap data is written only when the value read equals the compare data over the operand width. On success `rsp_ok` is 1. When the compare fails, `rsp_ok` is 0 and memory stays unchanged.
- R3: Every non-faulting response returns the value read from memory in `rsp_old`, with the bits above the operand width set to zero. A faulting response returns zero.
- R4: A quadword succeeds only if both of its 64-bit halves match. A mismatch in either half writes neither half.
- R5: A misaligned address returns fault code 1. The memory is not accessed and the lock is never raised. A word must be 4-byte aligned, a doubleword 8-byte aligned and a quadword 16-byte aligned.
- R6: A request whose write-permission flag is 0 returns fault code 2 and leaves memory untouched, even when the compare would have succeeded.
- R7: Size code 3, or size code 2 when XLEN is 32, returns fault code 3. When more than one fault applies, the code reported follows the priority size (3) over alignment (1) over permission (2).
- R8: `rsp_acq` echoes the acquire flag on every non-faulting response. `rsp_rel` echoes the release flag only when the compare succeeds. Both are 0 on a faulting response.
- R9: `rsp_valid` lasts exactly one cycle per request, and `req_ready` stays low from acceptance until that response. Every RAM beat takes place while `mem_lock` is high, and `mem_lock` is never high while `req_ready` is high. The lock lasts 2 cycles for a word or doubleword, 3 cycles for a failed quadword and 4 cycles for a successful quadword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears the RAM |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request accepted on this edge |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 0 word, 1 doubleword, 2 quadword |
| req_cmp | input | 128 | Compare data, low bits used for narrower sizes |
| req_swp | input | 128 | Swap data, low bits used for narrower sizes |
| req_aq | input | 1 | Acquire ordering flag |
| req_rl | input | 1 | Release ordering flag |
| req_wperm | input | 1 | Requester holds write permission |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_old | output | 128 | Value read from memory |
| rsp_ok | output | 1 | Compare succeeded and swap written |
| rsp_fault | output | 2 | 0 none, 1 misaligned, 2 no permission, 3 bad size |
| rsp_acq | output | 1 | Effective acquire ordering |
| rsp_rel | output | 1 | Effective release ordering |
| mem_lock | output | 1 | Other memory ports must hold off |

## Verification
The assertions check several rules on every cycle. The response strobe lasts one cycle, and the lock and the ready signal exclude each other. A success must return old data equal to the compare data over the operand width, and a non-faulting failure must return data that differs. Unused upper bits stay zero, release appears only with success, and a faulting response never follows a locked cycle. Other behaviour needs the bench's scenarios with its memory model. That covers lane selection, placing the quadword halves in consecutive rows, leaving memory untouched after a failed compare or a fault, fault priority, and the exact lock lengths.

// File: rtl/cas_unit.sv
`timescale 1ns/1ps
module cas_unit #(
  parameter int XLEN  = 64,
  parameter int DEPTH = 16,
  localparam int RW = $clog2(DEPTH),
  localparam int AW = RW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [127:0]  req_cmp,
  input  logic [127:0]  req_swp,
  input  logic          req_aq,
  input  logic          req_rl,
  input  logic          req_wperm,
  output logic          rsp_valid,
  output logic [127:0]  rsp_old,
  output logic          rsp_ok,
  output logic [1:0]    rsp_fault,
  output logic          rsp_acq,
  output logic          rsp_rel,
  output logic          mem_lock
);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_CMP, S_WR1, S_RSP} st_t;

  st_t            st;
  logic [63:0]    mem [DEPTH];
  logic [RW-1:0]  row_q;
  logic           lane_q;
  logic [1:0]     size_q;
  logic [127:0]   cmp_q, swp_q, old_q;
  logic [63:0]    rdata, lo_q;
  logic           aq_q, rl_q, ok_q;
  logic [1:0]     fault_q;

  logic           size_bad, mis;
  logic [1:0]     flt;
  logic [RW-1:0]  row_hi;
  logic [31:0]    lane;
  logic           hit;
  logic [63:0]    wdata0;
  logic [127:0]   old_c;

  assign size_bad = (req_size == 2'd3) || (req_size == 2'd2 && XLEN != 64);
  assign mis = (req_size == 2'd0) ? (req_addr[1:0] != 2'd0) :
               (req_size == 2'd1) ? (req_addr[2:0] != 3'd0) :
                                    (req_addr[3:0] != 4'd0);
  assign flt = size_bad ? 2'd3 : mis ? 2'd1 : !req_wperm ? 2'd2 : 2'd0;

  assign row_hi = {row_q[RW-1:1], 1'b1};
  assign lane   = lane_q ? rdata[63:32] : rdata[31:0];

  always_comb begin
    case (size_q)
      2'd0: begin
        hit    = (lane == cmp_q[31:0]);
        old_c  = {96'd0, lane};
        wdata0 = lane_q ? {swp_q[31:0], rdata[31:0]} : {rdata[63:32], swp_q[31:0]};
      end
      2'd1: begin
        hit    = (rdata == cmp_q[63:0]);
        old_c  = {64'd0, rdata};
        wdata0 = swp_q[63:0];
      end
      default: begin
        hit    = ({rdata, lo_q} == cmp_q);
        old_c  = {rdata, lo_q};
        wdata0 = swp_q[63:0];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      row_q   <= '0;
      lane_q  <= 1'b0;
      size_q  <= 2'd0;
      cmp_q   <= '0;
      swp_q   <= '0;
      old_q   <= '0;
      rdata   <= '0;
      lo_q    <= '0;
      aq_q    <= 1'b0;
      rl_q    <= 1'b0;
      ok_q    <= 1'b0;
      fault_q <= 2'd0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          row_q   <= req_addr[AW-1:3];
          lane_q  <= req_addr[2];
          size_q  <= req_size;
          cmp_q   <= req_cmp;
          swp_q   <= req_swp;
          aq_q    <= req_aq;
          rl_q    <= req_rl;
          fault_q <= flt;
          old_q   <= '0;
          ok_q    <= 1'b0;
          st      <= (flt != 2'd0) ? S_RSP : S_RD0;
        end
        S_RD0: begin
          rdata <= mem[row_q];
          st    <= (size_q == 2'd2) ? S_RD1 : S_CMP;
        end
        S_RD1: begin
          lo_q  <= rdata;
          rdata <= mem[row_hi];
          st    <= S_CMP;
        end
        S_CMP: begin
          old_q <= old_c;
          ok_q  <= hit;
          if (hit) mem[row_q] <= wdata0;
          st <= (hit && size_q == 2'd2) ? S_WR1 : S_RSP;
        end
        S_WR1: begin
          mem[row_hi] <= swp_q[127:64];
          st <= S_RSP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RSP);
  assign rsp_old   = old_q;
  assign rsp_ok    = ok_q;
  assign rsp_fault = fault_q;
  assign rsp_acq   = rsp_valid && fault_q == 2'd0 && aq_q;
  assign rsp_rel   = rsp_valid && ok_q && rl_q;
  assign mem_lock  = (st == S_RD0) || (st == S_RD1) || (st == S_CMP) || (st == S_WR1);

endmodule

// File: rtl/cas_unit_chk.sv
`timescale 1ns/1ps
module cas_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic [1:0]   req_size,
  input logic [127:0] req_cmp,
  input logic         rsp_valid,
  input logic [127:0] rsp_old,
  input logic         rsp_ok,
  input logic [1:0]   rsp_fault,
  input logic         rsp_acq,
  input logic         rsp_rel,
  input logic         mem_lock
);

  logic [127:0] c_cmp, c_mask;
  logic [1:0]   c_size;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_cmp  <= '0;
      c_size <= 2'd0;
    end else if (req_valid && req_ready) begin
      c_cmp  <= req_cmp;
      c_size <= req_size;
    end
  end

  assign c_mask = (c_size == 2'd0) ? {96'd0, {32{1'b1}}} :
                  (c_size == 2'd1) ? {64'd0, {64{1'b1}}} :
                  (c_size == 2'd2) ? {128{1'b1}} : 128'd0;

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_LOCK_EXCLUDES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> !req_ready); // R9
  AST_OK_MEANS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ok |-> ((rsp_old ^ c_cmp) & c_mask) == 128'd0); // R2
  AST_MISS_MEANS_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ok && rsp_fault == 2'd0 |-> ((rsp_old ^ c_cmp) & c_mask) != 128'd0); // R2
  AST_OLD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_old & ~c_mask) == 128'd0); // R3
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> !$past(mem_lock) && !rsp_ok); // R5
  AST_REL_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rel |-> rsp_valid && rsp_ok); // R8
  AST_ACQ_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_acq |-> rsp_valid && rsp_fault == 2'd0); // R8

endmodule

bind cas_unit cas_unit_chk u_chk (.*);

// File: tb/sim_cas_unit.sv
`timescale 1ns/1ps
module sim_cas_unit;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH) + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = 2'd0;
  logic [127:0] req_cmp = '0, req_swp = '0;
  logic req_aq = 1'b0, req_rl = 1'b0, req_wperm = 1'b1;
  logic rsp_valid, rsp_ok, rsp_acq, rsp_rel, mem_lock;
  logic [127:0] rsp_old;
  logic [1:0] rsp_fault;

  always #2.5 clk = ~clk;

  cas_unit #(.XLEN(64), .DEPTH(DEPTH)) u0 (.*);

  typedef struct {
    logic [127:0] old;
    logic ok, acq, rel;
    logic [1:0] fault;
    int lockc;
    string tag;
  } exp_t;

  exp_t sb[$];
  logic [63:0] model [DEPTH];
  int n_chk = 0, n_bad = 0, lc = 0;
  bit prev_rsp = 0, done = 0;

  task automatic fail(string tag, string what, logic [127:0] act, logic [127:0] exp);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (rsp_valid && prev_rsp) begin
      n_chk++; fail("R9", "response longer than one cycle", 1, 0);
    end
    prev_rsp = rsp_valid;
    if (mem_lock && req_ready) begin
      n_chk++; fail("R9", "lock with ready", 1, 0);
    end
    if (mem_lock) lc++;
    if (rsp_valid) begin
      exp_t e;
      n_chk++;
      if (sb.size() == 0) fail("R9", "unexpected response", 1, 0);
      else begin
        e = sb.pop_front();
        if (rsp_old !== e.old)     fail(e.tag, "old", rsp_old, e.old);
        if (rsp_ok !== e.ok)       fail(e.tag, "ok", rsp_ok, e.ok);
        if (rsp_fault !== e.fault) fail(e.tag, "fault", rsp_fault, e.fault);
        if (rsp_acq !== e.acq)     fail("R8", "acq", rsp_acq, e.acq);
        if (rsp_rel !== e.rel)     fail("R8", "rel", rsp_rel, e.rel);
        if (lc != e.lockc)         fail("R9", "lock cycles", lc, e.lockc);
      end
      lc = 0;
    end
  end

  task automatic cas(string tag, int addr, int size, logic [127:0] cmp, logic [127:0] swp,
                     bit aq, bit rl, bit wp);
    exp_t e;
    int row;
    logic [127:0] cur;
    bit mis;
    e.tag = tag; e.old = '0; e.ok = 0; e.acq = 0; e.rel = 0; e.lockc = 0;
    mis = (size == 0) ? (addr % 4 != 0) : (size == 1) ? (addr % 8 != 0) : (addr % 16 != 0);
    e.fault = (size == 3) ? 2'd3 : mis ? 2'd1 : !wp ? 2'd2 : 2'd0;
    if (e.fault == 2'd0) begin
      row = addr / 8;
      if (size == 0) begin
        cur = {96'd0, ((addr / 4) % 2 == 1) ? model[row][63:32] : model[row][31:0]};
        e.ok = (cur[31:0] == cmp[31:0]);
        if (e.ok) begin
          if ((addr / 4) % 2 == 1) model[row][63:32] = swp[31:0];
          else model[row][31:0] = swp[31:0];
        end
        e.lockc = 2;
      end else if (size == 1) begin
        cur = {64'd0, model[row]};
        e.ok = (cur[63:0] == cmp[63:0]);
        if (e.ok) model[row] = swp[63:0];
        e.lockc = 2;
      end else begin
        cur = {model[row + 1], model[row]};
        e.ok = (cur == cmp);
        if (e.ok) begin model[row] = swp[63:0]; model[row + 1] = swp[127:64]; end
        e.lockc = e.ok ? 4 : 3;
      end
      e.old = cur; e.acq = aq; e.rel = rl && e.ok;
    end
    sb.push_back(e);
    @(negedge clk);
    req_addr = AW'(addr); req_size = 2'(size); req_cmp = cmp; req_swp = swp;
    req_aq = aq; req_rl = rl; req_wperm = wp; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; fail("R9", "watchdog expired", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_lock !== 1'b0)
      fail("R9", "reset state", {req_ready, rsp_valid, mem_lock}, 3'b100);

    cas("R1", 0, 0, 0, 128'hA1A1_0001, 0, 0, 1);
    cas("R1", 4, 0, 0, 128'hB2B2_0002, 0, 0, 1);
    cas("R3", 0, 1, 128'h1, 0, 0, 0, 1);
    cas("R2", 4, 0, 128'h1234, 128'hDEAD, 0, 0, 1);
    cas("R2", 4, 0, 128'hB2B2_0002, 128'h5555_AAAA, 0, 0, 1);
    cas("R8", 8, 1, 0, 128'h0123_4567_89AB_CDEF, 1, 1, 1);
    cas("R8", 8, 1, 128'h7, 128'h9, 1, 1, 1);
    cas("R8", 8, 1, 128'h0123_4567_89AB_CDEF, 128'h42, 0, 1, 1);
    cas("R4", 16, 2, 0, {64'hCAFE_0000_0000_00C1, 64'hBEEF_0000_0000_00B1}, 1, 0, 1);
    cas("R4", 16, 2, {64'hCAFE_0000_0000_00C0, 64'hBEEF_0000_0000_00B1}, 128'h1, 0, 0, 1);
    cas("R4", 16, 2, {64'hCAFE_0000_0000_00C1, 64'hBEEF_0000_0000_00B0}, 128'h1, 0, 0, 1);
    cas("R4", 16, 2, {64'hCAFE_0000_0000_00C1, 64'hBEEF_0000_0000_00B1}, {64'h2, 64'h3}, 0, 1, 1);
    cas("R1", 24, 1, 0, 128'hFFFF, 0, 0, 1);
    cas("R5", 2, 0, 0, 128'h9, 1, 1, 1);
    cas("R5", 4, 1, 0, 128'h9, 0, 0, 1);
    cas("R5", 8, 2, 0, 128'h9, 0, 0, 1);
    cas("R5", 0, 1, 128'h1, 0, 0, 0, 1);
    cas("R6", 8, 1, 128'h42, 128'h77, 1, 1, 0);
    cas("R6", 8, 1, 128'h1, 0, 0, 0, 1);
    cas("R7", 32, 3, 0, 128'h5, 1, 0, 1);
    cas("R7", 33, 3, 0, 128'h5, 0, 0, 0);
    cas("R7", 1, 0, 0, 128'h5, 0, 0, 0);
    cas("R1", 124, 0, 0, 128'h7777_8888, 0, 0, 1);
    cas("R1", 120, 1, 128'h1, 0, 0, 0, 1);
    cas("R3", 16, 2, 128'h1, 0, 1, 1, 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule